// File: doc/BRIEF.md
# ADC Input Sequence Controller

This block walks an analog-to-digital converter through a set of differential input pairs, one conversion per pair. Software supplies a 16-bit enable mask, where bit i stands for input pair i. A start, from a software strobe, from an event trigger, or on its own in free-run mode, launches a sequence. The controller then drives the converter's 4-bit input select and a one-cycle conversion request for each enabled pair in turn, from the lowest index to the highest, and waits for the converter's done strobe after each request.

Each accepted result comes back as a one-cycle valid pulse, together with the converter data and the number of the input that produced it. A busy flag covers the whole sequence, from the accepted start until the last conversion completes. The enable mask is sampled when a sequence starts. When the mask is empty, a start performs a single conversion on a manually chosen input.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A sequence converts each input whose bit is set in the enable mask (bit i selects input i, driven on `mux_sel` as the unsigned value i) exactly once, in ascending index order, with `mux_sel` equal to the lowest enabled index when the first request is made.
- R2: `busy` goes high on the clock edge that accepts a start and stays high until the clock edge that accepts the done strobe of the last conversion of the sequence, where it goes low.
- R3: On the edge that accepts a done strobe, `res_valid` goes high for exactly one cycle, with `res_tag` equal to the input number just converted and `res_data` equal to `conv_data` as sampled with the strobe.
- R4: `conv_req` is a single-cycle pulse. It is issued in the cycle after a start is accepted, and in the cycle after each accepted done strobe that does not end the sequence. `mux_sel` holds its value from the request until the done strobe.
- R5: While idle, a one-cycle pulse on `sw_start` alone, or on `evt_trig` alone, starts a sequence.
- R6: A `sw_start` or `evt_trig` that arrives while `busy` is high is ignored. It neither changes the running sequence nor starts another one afterwards.
- R7: With `free_run` high, a new sequence starts on its own. `busy` is low for exactly one cycle between sequences, and the new sequence starts again from the lowest enabled input. Clearing `free_run` lets the current sequence finish, and no further sequence follows.
- R8: If the enable mask is zero when a start is accepted, exactly one conversion is made, on the input given by `manual_sel`, and `busy` covers that conversion.
- R9: A synchronous active-low reset clears `busy`, `conv_req` and `res_valid`, abandons any sequence in progress, and leaves the next sequence starting from its lowest enabled input.
- R10: A `conv_done` pulse while no conversion is outstanding is ignored. It produces no result and does not change `busy`.
- R11: The enable mask is captured when a start is accepted. Changing `en_mask` during a sequence does not alter the inputs that sequence converts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_mask | input | 16 | Enabled input pairs, bit i for input i |
| manual_sel | input | 4 | Input converted when the mask is empty |
| sw_start | input | 1 | Software start strobe |
| evt_trig | input | 1 | Event trigger strobe |
| free_run | input | 1 | Restart sequences automatically |
| conv_done | input | 1 | Converter finished the requested conversion |
| conv_data | input | 16 | Converter result, valid with conv_done |
| mux_sel | output | 4 | Input pair select to the converter |
| conv_req | output | 1 | One-cycle conversion request |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 16 | Conversion result |
| res_tag | output | 4 | Input number of the result |
| busy | output | 1 | Sequence in progress |

## Verification
The bench sweeps every single-input mask, every suffix mask, a long series of pseudo-random masks and the empty mask with several manual selections. For each it compares the ordered tags and data against a list computed from the mask, so a picker that skips the top input, repeats an input or runs in descending order produces a wrong sequence. It fires starts and changes the mask in the middle of a sequence: a design that queues the stray start runs a second sequence, and one that reads the mask live converts the wrong inputs. It measures the one-cycle idle gap in free-run mode, and it checks that a reset in mid-sequence and a stray done strobe while idle leave no ghost result and no stuck busy flag.

// File: rtl/adc_seq_pkg.sv
// Package: shared types of the input sequence controller.
// Assumes: a single clock domain; the enum is shared by the control FSM and the top.
package adc_seq_pkg;

    // Control states: idle, request pulse, waiting for the converter
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

endpackage

// File: rtl/adc_seq_trigger.sv
// Module: start qualifier.
// Merges the software strobe, the event trigger and free-run mode into one
// start pulse, which is raised only while the sequencer is idle.
// Assumes: the strobes are synchronous to clk; a strobe seen while busy is dropped.
module adc_seq_trigger (
    input  logic idle,
    input  logic sw_start,
    input  logic evt_trig,
    input  logic free_run,
    output logic start_fire
);

    // Accept any start source only when no sequence is running
    always_comb begin
        start_fire = idle & (sw_start | evt_trig | free_run);
    end

endmodule

// File: rtl/adc_seq_pick.sv
// Module: lowest-enabled-index finder.
// Returns the lowest set bit of mask whose index is at least lo.
// Assumes: lo is one bit wider than an index, so that lo == N means "none left".
module adc_seq_pick #(
    parameter int N_IN  = 16,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  mask,
    input  logic [SEL_W:0]   lo,
    output logic             found,
    output logic [SEL_W-1:0] idx
);

    localparam int LO_W = SEL_W + 1;

    logic [N_IN-1:0] eligible;

    // Keep only the mask bits at or above the lower bound
    for (genvar g = 0; g < N_IN; g++) begin : g_elig
        assign eligible[g] = mask[g] & (lo <= LO_W'(g));
    end

    // Priority scan from the top down, so the lowest eligible bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
// Module: sequence control state machine.
// Captures the mask on start, steps the input pointer upward over the captured
// mask, issues one request per input and ends the sequence after the last done.
// Assumes: the converter answers every request with exactly one conv_done, no
// earlier than the cycle after the request.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_fire,
    input  logic [N_IN-1:0]  en_mask,
    input  logic [SEL_W-1:0] manual_sel,
    input  logic             first_found,
    input  logic [SEL_W-1:0] first_idx,
    input  logic             next_found,
    input  logic [SEL_W-1:0] next_idx,
    input  logic             conv_done,
    output seq_state_t       state,
    output logic [N_IN-1:0]  mask_q,
    output logic [SEL_W-1:0] cur_idx,
    output logic             accept
);

    // A done strobe counts only while a conversion is outstanding
    always_comb begin
        accept = (state == ST_WAIT) && conv_done;
    end

    // State, pointer and mask snapshot registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
            mask_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_fire) begin
                        mask_q  <= en_mask;
                        cur_idx <= first_found ? first_idx : manual_sel;
                        state   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (next_found) begin
                            cur_idx <= next_idx;
                            state   <= ST_REQ;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: the pointer only moves upward inside a sequence
    p_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && next_found) |=> (cur_idx > $past(cur_idx)));

    // R1: with a non-empty snapshot every requested input is enabled in it
    p_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ && mask_q != '0) |-> mask_q[cur_idx]);

    // R4: the request state lasts a single cycle
    p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ) |=> (state == ST_WAIT));

endmodule

// File: rtl/adc_seq_result.sv
// Module: result capture.
// Registers converter data and the input number on each accepted done strobe
// and raises a one-cycle valid pulse.
// Assumes: tag_in holds the select that was driven for the finished conversion.
module adc_seq_result #(
    parameter int RES_W = 16,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [RES_W-1:0] data_in,
    input  logic [SEL_W-1:0] tag_in,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [SEL_W-1:0] res_tag
);

    // Capture data and tag together with the valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_tag   <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_data <= data_in;
                res_tag  <= tag_in;
            end
        end
    end

    // R3: the tag matches the select that was driven during the conversion
    p_tag_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_tag == $past(tag_in)));

    // R3: a result pulse never lasts two cycles
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: ADC input sequence controller (top).
// Scans the enabled differential inputs from low to high, one conversion each,
// tags each result with its input number and holds busy for the whole sequence.
// Assumes: synchronous active-low reset; the converter returns one conv_done per
// conv_req; the converter is not part of this block.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int N_IN  = 16,
    parameter int SEL_W = $clog2(N_IN),
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  en_mask,
    input  logic [SEL_W-1:0] manual_sel,
    input  logic             sw_start,
    input  logic             evt_trig,
    input  logic             free_run,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic [SEL_W-1:0] mux_sel,
    output logic             conv_req,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [SEL_W-1:0] res_tag,
    output logic             busy
);

    localparam int LO_W = SEL_W + 1;

    seq_state_t       state;
    logic [N_IN-1:0]  mask_q;
    logic [SEL_W-1:0] cur_idx;
    logic             accept;
    logic             start_fire;
    logic             first_found;
    logic [SEL_W-1:0] first_idx;
    logic             next_found;
    logic [SEL_W-1:0] next_idx;
    logic [LO_W-1:0]  next_lo;

    // Status and converter-facing outputs decoded from the control state
    always_comb begin
        busy     = (state != ST_IDLE);
        conv_req = (state == ST_REQ);
        mux_sel  = cur_idx;
        next_lo  = LO_W'(cur_idx) + LO_W'(1);
    end

    adc_seq_trigger u_trig (
        .idle       (!busy),
        .sw_start   (sw_start),
        .evt_trig   (evt_trig),
        .free_run   (free_run),
        .start_fire (start_fire)
    );

    adc_seq_pick #(.N_IN(N_IN), .SEL_W(SEL_W)) u_pick_first (
        .mask  (en_mask),
        .lo    ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    adc_seq_pick #(.N_IN(N_IN), .SEL_W(SEL_W)) u_pick_next (
        .mask  (mask_q),
        .lo    (next_lo),
        .found (next_found),
        .idx   (next_idx)
    );

    adc_seq_fsm #(.N_IN(N_IN), .SEL_W(SEL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_fire  (start_fire),
        .en_mask     (en_mask),
        .manual_sel  (manual_sel),
        .first_found (first_found),
        .first_idx   (first_idx),
        .next_found  (next_found),
        .next_idx    (next_idx),
        .conv_done   (conv_done),
        .state       (state),
        .mask_q      (mask_q),
        .cur_idx     (cur_idx),
        .accept      (accept)
    );

    adc_seq_result #(.RES_W(RES_W), .SEL_W(SEL_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .data_in   (conv_data),
        .tag_in    (mux_sel),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_tag   (res_tag)
    );

    // R2: busy holds until the final done strobe of the sequence
    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(accept && !next_found)) |=> busy);

    // R4: the select is stable while the converter works
    p_sel_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> $stable(mux_sel));

    // R10: a result appears only after an outstanding request
    p_no_ghost_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(busy));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] en_mask = '0;
    logic [3:0]  manual_sel = '0;
    logic        sw_start = 1'b0;
    logic        evt_trig = 1'b0;
    logic        free_run = 1'b0;
    logic        stub_done = 1'b0;
    logic        extra_done = 1'b0;
    logic [15:0] stub_data = '0;
    logic [3:0]  mux_sel;
    logic        conv_req;
    logic        res_valid;
    logic [15:0] res_data;
    logic [3:0]  res_tag;
    logic        busy;

    int checks = 0;
    int failures = 0;
    int got_n = 0;
    int req_n = 0;
    logic [3:0]  got_tag [0:63];
    logic [15:0] got_data [0:63];
    logic [3:0]  stub_sel = '0;
    int          stub_cnt = 0;
    logic        prev_req = 1'b0;
    logic        prev_val = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_mask    (en_mask),
        .manual_sel (manual_sel),
        .sw_start   (sw_start),
        .evt_trig   (evt_trig),
        .free_run   (free_run),
        .conv_done  (stub_done | extra_done),
        .conv_data  (stub_data),
        .mux_sel    (mux_sel),
        .conv_req   (conv_req),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_tag    (res_tag),
        .busy       (busy)
    );

    function automatic logic [15:0] conv_val(input logic [3:0] s);
        return 16'h3C00 + 16'(s) * 16'd257;
    endfunction

    function automatic int low_of(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Converter stub with fixed latency
    always @(posedge clk) begin
        if (!rst_n) begin
            stub_cnt  <= 0;
            stub_done <= 1'b0;
        end else begin
            stub_done <= 1'b0;
            if (conv_req) begin
                stub_cnt <= LAT;
                stub_sel <= mux_sel;
            end else if (stub_cnt != 0) begin
                stub_cnt <= stub_cnt - 1;
                if (stub_cnt == 1) begin
                    stub_done <= 1'b1;
                    stub_data <= conv_val(stub_sel);
                end
            end
        end
    end

    // Monitor: record results and check pulse widths
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid && got_n < 64) begin
                got_tag[got_n]  = res_tag;
                got_data[got_n] = res_data;
                got_n++;
            end
            if (conv_req) req_n++;
            if (conv_req && prev_req) chk(0, "R4", "conv_req two cycles", 1, 0);
            if (res_valid && prev_val) chk(0, "R3", "res_valid two cycles", 1, 0);
        end
        prev_req = conv_req;
        prev_val = res_valid;
    end

    task automatic wait_idle(input string req);
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 2000, req, "busy stuck", guard, 0);
        @(negedge clk);
    endtask

    task automatic check_list(input logic [15:0] m, input int reps, input string req);
        int k = 0;
        int expn = (m == 0) ? reps : reps * $countones(m);
        chk(got_n == expn, req, "result count", got_n, expn);
        for (int r = 0; r < reps; r++) begin
            for (int i = 0; i < 16; i++) begin
                if ((m == 0 && i == int'(manual_sel)) || m[i]) begin
                    if (k < got_n) begin
                        chk(got_tag[k] == 4'(i), req, "tag order (R1/R3)", got_tag[k], i);
                        chk(got_data[k] == conv_val(4'(i)), "R3", "data", got_data[k],
                            conv_val(4'(i)));
                    end
                    k++;
                end
            end
        end
    endtask

    // One sequence with optional mid-run disturbance (R6, R11)
    task automatic run_seq(input logic [15:0] m, input bit use_evt, input bit poke);
        int first = (m == 0) ? int'(manual_sel) : low_of(m);
        @(negedge clk);
        en_mask = m;
        got_n = 0;
        req_n = 0;
        if (use_evt) evt_trig = 1'b1; else sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        evt_trig = 1'b0;
        chk(busy == 1'b1, use_evt ? "R5" : "R2", "busy after start", busy, 1);
        chk(conv_req == 1'b1, "R4", "first request", conv_req, 1);
        chk(int'(mux_sel) == first, m == 0 ? "R8" : "R1", "first select", mux_sel, first);
        if (poke) begin
            repeat (2) @(negedge clk);
            en_mask = ~m;
            sw_start = 1'b1;
            evt_trig = 1'b1;
            @(negedge clk);
            sw_start = 1'b0;
            evt_trig = 1'b0;
        end
        wait_idle("R2");
        check_list(m, 1, poke ? "R11" : "R1");
        chk(req_n == ((m == 0) ? 1 : $countones(m)), poke ? "R6" : "R4", "request count",
            req_n, (m == 0) ? 1 : $countones(m));
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b0, "R6", "no deferred start", busy, 0);
        end
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", "reset busy", busy, 0);
        chk(conv_req == 1'b0, "R9", "reset conv_req", conv_req, 0);
        chk(res_valid == 1'b0, "R9", "reset res_valid", res_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Single-input and suffix masks
        for (int i = 0; i < 16; i++) run_seq(16'(1) << i, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) run_seq(16'hFFFF << i, 1'b1, 1'b0);
        // Pseudo-random masks, some disturbed mid-sequence
        for (int n = 0; n < 48; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_seq(lfsr, n[0], n[1]);
        end
        run_seq(16'h8001, 1'b0, 1'b1);
        // Empty mask: manual select (R8)
        for (int s = 0; s < 16; s += 5) begin
            manual_sel = 4'(s);
            run_seq(16'h0000, s[0], 1'b0);
        end

        // Stray done while idle (R10)
        @(negedge clk);
        got_n = 0;
        extra_done = 1'b1;
        @(negedge clk);
        extra_done = 1'b0;
        @(negedge clk);
        chk(got_n == 0, "R10", "ghost result", got_n, 0);
        chk(busy == 1'b0, "R10", "busy after stray done", busy, 0);

        // Free-run mode (R7)
        begin
            int gap = 0;
            en_mask = 16'h0A41;
            got_n = 0;
            free_run = 1'b1;
            @(negedge clk);
            chk(busy == 1'b1, "R7", "free-run self start", busy, 1);
            while (busy) @(negedge clk);
            while (!busy && gap < 10) begin
                gap++;
                @(negedge clk);
            end
            chk(gap == 1, "R7", "idle gap", gap, 1);
            chk(int'(mux_sel) == 0 && conv_req, "R7", "restart at lowest", mux_sel, 0);
            free_run = 1'b0;
            wait_idle("R7");
            check_list(16'h0A41, 2, "R7");
            repeat (5) @(negedge clk);
            chk(busy == 1'b0, "R7", "stops after free-run cleared", busy, 0);
        end

        // Reset in mid-sequence (R9)
        @(negedge clk);
        en_mask = 16'hFFFF;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
        chk(conv_req == 1'b0, "R9", "conv_req after reset", conv_req, 0);
        chk(res_valid == 1'b0, "R9", "res_valid after reset", res_valid, 0);
        got_n = 0;
        repeat (8) @(negedge clk);
        chk(got_n == 0 && !busy, "R9", "no result after reset", got_n, 0);
        run_seq(16'h0030, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule